// File: doc/BRIEF.md
# Split-Screen Display Address Generator

This block produces the display-memory fetch addresses and the fine horizontal pixel shift for a raster display that can be divided into two vertical regions. The upper region begins at a host-programmed frame start address. Each following line advances by a programmed pitch. At a programmed compare line the lower region takes over. That region always fetches from address zero and keeps stepping by the same pitch until the frame ends.

An external timing generator supplies a frame-start pulse, a line-start pulse with the current line number, a per-byte character strobe and a vertical-retrace level. The host supplies its settings as plain register values. The frame start address is captured only at the frame-start pulse, so a change made during a frame shows up one frame later. The fine pan value and the pan-suppression control are captured only during vertical retrace. The shift handed to the pixel serializer changes only at a line start. When suppression is enabled, the lower region is always shifted by zero.

Top module: `split_addr_gen`

## Requirements
- R1: While reset is low at a clock edge, `line_base`, `char_addr`, `pan_shift` and `split_region` are all 0 after that edge.
- R2: On the line-start of line 0 (when the split line is not 0), the line base becomes the value `start_addr` had at the most recent `frame_start` pulse; changes to `start_addr` after that pulse have no effect on the current frame.
- R3: On a line-start of any other line outside the split point, the line base becomes the previous line base plus twice `pitch_words`, modulo 2^16.
- R4: On the line-start whose `line_num` equals `split_line`, the line base becomes 0 and `split_region` becomes 1; it stays 1 until the next `frame_start`, and later lines step from 0 by the pitch.
- R5: `char_addr` is loaded with the new line base at each line-start and increments by 1 on each `char_strobe`; a line-start in the same cycle as a strobe takes priority.
- R6: All outputs are registered: the effect of a strobe is visible one clock after the edge that samples it.
- R7: `pan_shift` changes only at a line-start, and it then takes the `fine_pan` value captured during the latest vertical-retrace interval.
- R8: With the captured suppression bit set, every line from the split line to the end of the frame gets `pan_shift` 0; with it clear, the lower region gets the same shift as the upper region.
- R9: Changes to `fine_pan` or `pan_suppress` while `vretrace` is low have no effect on `pan_shift` until the next retrace interval.
- R10: A `split_line` of 0 puts the whole frame, from line 0, in the lower region with base 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse before line 0 of a frame |
| line_start | input | 1 | One-cycle pulse at the start of each visible line |
| char_strobe | input | 1 | One pulse per byte fetched |
| vretrace | input | 1 | High during vertical retrace |
| line_num | input | 10 | Current scan line, valid with `line_start` |
| start_addr | input | 16 | Host frame start address (byte) |
| pitch_words | input | 8 | Host line pitch in 16-bit words |
| split_line | input | 10 | Host compare line for the lower region |
| fine_pan | input | 3 | Host fine pan, 0 to 7 pixels |
| pan_suppress | input | 1 | Host control: zero pan in the lower region |
| line_base | output | 16 | Base address of the current line |
| char_addr | output | 16 | Address of the current byte fetch |
| pan_shift | output | 3 | Fine shift for the pixel serializer |
| split_region | output | 1 | High while the lower region is being scanned |

## Verification
The bench targets several corner cases. One is a start address rewritten mid-frame: a design that latched it continuously would tear the current frame. Another is a fine-pan value changed outside retrace: a design that tracked it live would shift mid-frame or mid-line. The bench also checks that the lower region is zeroed only under suppression, since a design that ignored the control bit would make that region jitter or freeze it. Finally, it drives a split at line 0, a wrapping pitch step, and a line-start that lands on a character strobe. A wrong priority in the line-base source, or a wrong priority between reload and increment, would give a wrong base or an off-by-one character address in those cases.

// File: rtl/sag_pkg.sv
// Package: shared selector type for the split-screen address generator.
// Assumes nothing beyond a synthesizable enum encoding.
package sag_pkg;
    // Which source feeds the next line base at a line start.
    typedef enum logic [1:0] {
        BASE_HOLD  = 2'd0,
        BASE_FRAME = 2'd1,
        BASE_STEP  = 2'd2,
        BASE_SPLIT = 2'd3
    } base_src_e;
endpackage

// File: rtl/sag_line_addr.sv
// Module: sag_line_addr
// Holds the line base and per-byte address. At a line start both load
// the base picked by base_src; a byte strobe alone increments the byte
// address. Assumes ADDR_W exceeds PITCH_W + 1 so the doubled pitch fits.
module sag_line_addr #(
    parameter int ADDR_W  = 16,
    parameter int PITCH_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_start,
    input  logic                  char_strobe,
    input  sag_pkg::base_src_e    base_src,
    input  logic [ADDR_W-1:0]     frame_base,
    input  logic [PITCH_W-1:0]    pitch_words,
    output logic [ADDR_W-1:0]     line_base,
    output logic [ADDR_W-1:0]     char_addr
);
    import sag_pkg::*;

    localparam int STEP_W = PITCH_W + 1;

    logic [STEP_W-1:0] step_raw;
    logic [ADDR_W-1:0] step_bytes;
    logic [ADDR_W-1:0] next_base;

    // Pitch is counted in words, so one line is twice that many bytes.
    assign step_raw   = {pitch_words, 1'b0};
    assign step_bytes = ADDR_W'(step_raw);

    // Select the base the next line starts from.
    always_comb begin
        unique case (base_src)
            BASE_FRAME: next_base = frame_base;
            BASE_STEP:  next_base = line_base + step_bytes;
            BASE_SPLIT: next_base = '0;
            default:    next_base = line_base;
        endcase
    end

    // Register line base and byte address; line start wins over a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_base <= '0;
            char_addr <= '0;
        end else if (line_start) begin
            line_base <= next_base;
            char_addr <= next_base;
        end else if (char_strobe) begin
            char_addr <= char_addr + 1'b1;
        end
    end
endmodule

// File: rtl/sag_pan_sel.sv
// Module: sag_pan_sel
// Captures the host pan value and suppression bit while retrace is high,
// then updates the serializer shift only at line starts. Assumes the
// caller says whether the starting line lies in the lower region.
module sag_pan_sel #(
    parameter int PAN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vretrace,
    input  logic [PAN_W-1:0] fine_pan,
    input  logic             pan_suppress,
    input  logic             line_start,
    input  logic             lower_line,
    output logic [PAN_W-1:0] pan_shift
);
    logic [PAN_W-1:0] pan_held;
    logic             supp_held;

    // Shadow copy of host pan controls, refreshed only in retrace.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pan_held  <= '0;
            supp_held <= 1'b0;
        end else if (vretrace) begin
            pan_held  <= fine_pan;
            supp_held <= pan_suppress;
        end
    end

    // Apply the held shift at line starts, zeroed in a suppressed lower region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pan_shift <= '0;
        end else if (line_start) begin
            pan_shift <= (lower_line && supp_held) ? '0 : pan_held;
        end
    end
endmodule

// File: rtl/split_addr_gen.sv
// Module: split_addr_gen (top)
// Generates line base, byte fetch address and fine shift for a display
// split into an upper region (programmable start) and a lower region
// (fixed at address 0) beginning at a compare line. Assumes frame_start
// never coincides with line_start, and vretrace is low while lines run.
module split_addr_gen #(
    parameter int ADDR_W  = 16,
    parameter int PITCH_W = 8,
    parameter int LINE_W  = 10,
    parameter int PAN_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic               char_strobe,
    input  logic               vretrace,
    input  logic [LINE_W-1:0]  line_num,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [PITCH_W-1:0] pitch_words,
    input  logic [LINE_W-1:0]  split_line,
    input  logic [PAN_W-1:0]   fine_pan,
    input  logic               pan_suppress,
    output logic [ADDR_W-1:0]  line_base,
    output logic [ADDR_W-1:0]  char_addr,
    output logic [PAN_W-1:0]   pan_shift,
    output logic               split_region
);
    import sag_pkg::*;

    logic [ADDR_W-1:0] frame_base;
    logic              split_hit;
    logic              lower_line;
    base_src_e         base_src;

    // Frame start address, captured once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_base <= '0;
        end else if (frame_start) begin
            frame_base <= start_addr;
        end
    end

    assign split_hit  = line_start && (line_num == split_line);
    assign lower_line = split_region || split_hit;

    // Lower-region flag: set at the compare line, cleared per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_region <= 1'b0;
        end else if (frame_start) begin
            split_region <= 1'b0;
        end else if (split_hit) begin
            split_region <= 1'b1;
        end
    end

    // Pick the base source; the compare line outranks line 0.
    always_comb begin
        if (!line_start)
            base_src = BASE_HOLD;
        else if (split_hit)
            base_src = BASE_SPLIT;
        else if (line_num == '0)
            base_src = BASE_FRAME;
        else
            base_src = BASE_STEP;
    end

    sag_line_addr #(
        .ADDR_W  (ADDR_W),
        .PITCH_W (PITCH_W)
    ) u_line_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .char_strobe (char_strobe),
        .base_src    (base_src),
        .frame_base  (frame_base),
        .pitch_words (pitch_words),
        .line_base   (line_base),
        .char_addr   (char_addr)
    );

    sag_pan_sel #(
        .PAN_W (PAN_W)
    ) u_pan_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .vretrace     (vretrace),
        .fine_pan     (fine_pan),
        .pan_suppress (pan_suppress),
        .line_start   (line_start),
        .lower_line   (lower_line),
        .pan_shift    (pan_shift)
    );
endmodule

// File: rtl/sag_checker.sv
// Module: sag_checker
// Port-level temporal checks for split_addr_gen, attached by bind.
module sag_checker #(
    parameter int ADDR_W  = 16,
    parameter int PITCH_W = 8,
    parameter int LINE_W  = 10,
    parameter int PAN_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic               line_start,
    input logic               char_strobe,
    input logic [LINE_W-1:0]  line_num,
    input logic [PITCH_W-1:0] pitch_words,
    input logic [LINE_W-1:0]  split_line,
    input logic [ADDR_W-1:0]  line_base,
    input logic [ADDR_W-1:0]  char_addr,
    input logic [PAN_W-1:0]   pan_shift,
    input logic               split_region
);
    // R4: compare line zeroes the base and enters the lower region.
    a_r4_split_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && line_num == split_line) |=> (line_base == '0 && split_region));

    // R3: ordinary lines step by twice the pitch.
    a_r3_pitch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && line_num != '0 && line_num != split_line)
        |=> (line_base == $past(line_base) + ADDR_W'({$past(pitch_words), 1'b0})));

    // R5: byte address reloads from the base at a line start.
    a_r5_char_reload: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (char_addr == line_base));

    // R5: byte address increments on a lone strobe.
    a_r5_char_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (char_strobe && !line_start) |=> (char_addr == $past(char_addr) + 1'b1));

    // R7: shift holds between line starts.
    a_r7_pan_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(pan_shift));

    // R4: lower region only ends at a frame start.
    a_r4_region_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (split_region && !frame_start) |=> split_region);
endmodule

bind split_addr_gen sag_checker #(
    .ADDR_W  (ADDR_W),
    .PITCH_W (PITCH_W),
    .LINE_W  (LINE_W),
    .PAN_W   (PAN_W)
) u_sag_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .line_start   (line_start),
    .char_strobe  (char_strobe),
    .line_num     (line_num),
    .pitch_words  (pitch_words),
    .split_line   (split_line),
    .line_base    (line_base),
    .char_addr    (char_addr),
    .pan_shift    (pan_shift),
    .split_region (split_region)
);

// File: tb/split_addr_gen_bench.sv
`timescale 1ns/1ps
module split_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, line_start = 1'b0, char_strobe = 1'b0, vretrace = 1'b0;
    logic [9:0]  line_num = '0, split_line = 10'd1023;
    logic [15:0] start_addr = '0;
    logic [7:0]  pitch_words = '0;
    logic [2:0]  fine_pan = '0;
    logic        pan_suppress = 1'b0;
    logic [15:0] line_base, char_addr;
    logic [2:0]  pan_shift;
    logic        split_region;

    int    checks = 0, errors = 0;
    bit    cmp_en = 0, done = 0;
    string cur_req = "R1";

    // reference state
    int m_start = 0, m_base = 0, m_char = 0, m_pan = 0, m_pan_sh = 0;
    bit m_split = 0, m_sup_sh = 0;

    split_addr_gen u_split_addr_gen (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .char_strobe(char_strobe), .vretrace(vretrace), .line_num(line_num),
        .start_addr(start_addr), .pitch_words(pitch_words), .split_line(split_line),
        .fine_pan(fine_pan), .pan_suppress(pan_suppress), .line_base(line_base),
        .char_addr(char_addr), .pan_shift(pan_shift), .split_region(split_region)
    );

    always #2 clk = ~clk;

    // Behavioural reference, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_base = 0; m_char = 0; m_pan = 0;
            m_pan_sh = 0; m_sup_sh = 0; m_split = 0;
        end else begin
            if (line_start) begin
                if (line_num == split_line) begin
                    m_base = 0; m_split = 1;
                end else if (line_num == 0) begin
                    m_base = m_start;
                end else begin
                    m_base = (m_base + 2 * int'(pitch_words)) % 65536;
                end
                m_char = m_base;
                m_pan  = (m_split && m_sup_sh) ? 0 : m_pan_sh;
            end else if (char_strobe) begin
                m_char = (m_char + 1) % 65536;
            end
            if (frame_start) begin
                m_start = int'(start_addr); m_split = 0;
            end
            if (vretrace) begin
                m_pan_sh = int'(fine_pan); m_sup_sh = pan_suppress;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output on every falling edge (R6: one-clock latency).
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(int'(line_base) == m_base, cur_req, "line_base", int'(line_base), m_base);
            chk(int'(char_addr) == m_char, cur_req, "char_addr", int'(char_addr), m_char);
            chk(int'(pan_shift) == m_pan, cur_req, "pan_shift", int'(pan_shift), m_pan);
            chk(split_region == m_split, cur_req, "split_region", int'(split_region), int'(m_split));
        end
    end

    task automatic retrace(input int pan, input bit sup);
        @(negedge clk);
        fine_pan = 3'(pan); pan_suppress = sup; vretrace = 1'b1;
        repeat (3) @(negedge clk);
        vretrace = 1'b0;
    endtask

    // One frame: nlines lines of nchars bytes; optional mid-frame host writes.
    task automatic frame(input int nlines, input int nchars, input bit overlap,
                         input int new_start, input int new_pan);
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int l = 0; l < nlines; l++) begin
            line_num = 10'(l); line_start = 1'b1; char_strobe = overlap;
            @(negedge clk);
            line_start = 1'b0; char_strobe = 1'b1;
            repeat (nchars) @(negedge clk);
            char_strobe = 1'b0;
            if (l == 1 && new_start >= 0) start_addr = 16'(new_start);
            if (l == 2 && new_pan >= 0) begin
                fine_pan = 3'(new_pan); pan_suppress = ~pan_suppress;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        cur_req = "R1";
        chk(line_base == 16'd0, "R1", "reset line_base", int'(line_base), 0);
        chk(char_addr == 16'd0, "R1", "reset char_addr", int'(char_addr), 0);
        chk(pan_shift == 3'd0, "R1", "reset pan_shift", int'(pan_shift), 0);
        chk(split_region == 1'b0, "R1", "reset split_region", int'(split_region), 0);
        cmp_en = 1;
        rst_n = 1'b1;

        // Start latch and pitch stepping; start rewritten mid-frame.
        cur_req = "R2";
        start_addr = 16'h1000; pitch_words = 8'd40; split_line = 10'd1023;
        retrace(3, 0);
        frame(6, 5, 0, 16'h2345, -1);
        cur_req = "R3";
        frame(6, 4, 0, -1, -1);

        // Split with and without suppression.
        cur_req = "R4";
        split_line = 10'd3;
        retrace(5, 0);
        frame(7, 3, 0, -1, -1);
        cur_req = "R8";
        retrace(5, 1);
        frame(7, 3, 0, -1, -1);

        // Host pan writes outside retrace must not act (R9), then act after retrace (R7).
        cur_req = "R9";
        frame(7, 3, 0, -1, 2);
        cur_req = "R7";
        retrace(6, 0);
        frame(7, 3, 0, -1, -1);

        // Line start coinciding with a byte strobe.
        cur_req = "R5";
        frame(5, 6, 1, -1, -1);

        // Split on line 0.
        cur_req = "R10";
        split_line = 10'd0;
        retrace(4, 1);
        frame(5, 3, 0, -1, -1);

        // Wrapping pitch step near the top of the address space.
        cur_req = "R3";
        split_line = 10'd1023; pitch_words = 8'd255; start_addr = 16'hFF00;
        retrace(1, 0);
        frame(2, 2, 0, -1, -1);
        frame(5, 2, 0, -1, -1);

        // R6 is covered by every per-clock comparison above.
        cur_req = "R6";
        repeat (3) @(negedge clk);
        cmp_en = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule